// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a digital model of a four-section clock driver with programmable skew. It runs on a fast time-unit clock, where one rising edge is one time unit. From that clock it builds a nominal output clock whose period is N units. A three-level range input picks N. Eight outputs are arranged as four pairs. Two three-level selects per pair choose that pair's function: a signed phase offset in time units, a divide-by-2 or divide-by-4 of the nominal clock, or, in one section, the nominal clock inverted.

Sections one and two shift in single-unit steps. Sections three and four shift in two-unit steps, and their two corner codes give the divided or inverted functions. A test level on a separate three-level input bypasses the phase generator, so every pair then follows a plain reference level through its own invert or divide function. All outputs are registered, so each output reflects the counter state of the previous time-unit edge. Select and range changes are latched only when a nominal period ends, which keeps pulses whole.

Top module: `skew_clk_matrix`

## Requirements
- R1: The nominal period is N ticks, where N is 44 for range code LOW, 26 for MID and 16 for HIGH. An output on the zero code (F1=MID, F0=MID) is high for the first N/2 ticks of each period and low for the rest. The phase count is zero in the first cycle after reset is released, and each output shows the count of the preceding edge.
- R2: Each select is combined into an index 3*F1+F0, with levels LOW=0, MID=1, HIGH=2. Pairs 1 and 2 apply the offset k = index-4 units: an output is high when ((count-k) mod N) < N/2.
- R3: Pair 3 maps index 1..7 to offsets -6..+6 in steps of two. Index 0 gives divide-by-2: high during even periods. Index 8 gives divide-by-4: high during the first two of every four periods.
- R4: Pair 4 decodes like pair 3, except that index 8 gives the nominal zero-offset clock inverted.
- R5: Both outputs of a pair always carry the same value.
- R6: Each three-level select is a 2-bit code: 00 = LOW, 01 = MID, 10 = HIGH. The code 11 behaves exactly as MID.
- R7: Range and function selects are latched at reset and at the last tick of each nominal period. A change made mid-period takes effect from the next period onward.
- R8: When the test select is MID or HIGH, the pair outputs follow the reference level one edge late. Shift codes pass the level as is, whatever their offset, and the inverted code passes its complement. Divide codes count the rising edges of the reference seen in test mode: divide-by-2 is bit 0 of that count and divide-by-4 is bit 1.
- R9: While the synchronous active-low reset is low, all outputs are low and the phase count and the reference edge count return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-unit clock, one edge per unit |
| rst_n | input | 1 | Synchronous reset, active low |
| range_sel | input | 2 | Three-level range select picking N |
| test_sel | input | 2 | Three-level test select; MID or HIGH bypasses the generator |
| ref_lvl | input | 1 | Reference level used in test mode |
| sel_f1 | input | 8 | Upper function select, pair p in bits [2p+1:2p] |
| sel_f0 | input | 8 | Lower function select, pair p in bits [2p+1:2p] |
| q0 | output | 4 | First output of each pair, bit p is pair p+1 |
| q1 | output | 4 | Second output of each pair, bit p is pair p+1 |

## Verification
Every range code is crossed with all nine function indices, and each run covers four full periods. This separates the step sizes of the sections, shows which way each offset wraps, and tells the divide-by-2, divide-by-4 and inverted corner codes apart. A mixed-code run changes the selects and the range mid-period, which shows whether latching waits for the period boundary. Test-mode runs drive an irregular reference pattern under each function index. They separate plain following from inversion and from edge-counting division, and they use code 11 to show that it decodes as MID.

// File: rtl/skew_matrix_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the skew clock output matrix.
// Assumes three-level selects arrive as 2-bit codes (00 low, 01 mid, 10 high, 11 read as mid).
package skew_matrix_pkg;

    typedef enum logic [1:0] {
        FN_SHIFT = 2'd0,
        FN_DIV2  = 2'd1,
        FN_DIV4  = 2'd2,
        FN_INV   = 2'd3
    } fn_kind_e;

    typedef struct packed {
        fn_kind_e           kind;
        logic signed [3:0]  offset;
    } pair_fn_t;

    // Fold the unused code 11 onto the middle level.
    function automatic logic [1:0] lvl_of(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'b01 : raw;
    endfunction

    // Nine-way index 3*upper + lower.
    function automatic logic [3:0] code_index(input logic [1:0] hi, input logic [1:0] lo);
        logic [3:0] a;
        logic [3:0] b;
        a = {2'b00, lvl_of(hi)};
        b = {2'b00, lvl_of(lo)};
        return a * 4'd3 + b;
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
`timescale 1ns/1ps
// Phase generator: counts ticks within a nominal period and counts periods modulo four.
// Assumes the range select may change at any time; it is latched only at reset and period end.
module skew_phase_gen #(
    parameter int N_LO  = 44,
    parameter int N_MID = 26,
    parameter int N_HI  = 16,
    parameter int PHW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      range_sel,
    output logic [PHW-1:0]  ph,
    output logic [1:0]      seg,
    output logic [PHW-1:0]  n_cur,
    output logic            period_end
);
    import skew_matrix_pkg::*;

    logic [PHW-1:0] n_sel;

    // Map the range level onto a period length.
    always_comb begin
        case (lvl_of(range_sel))
            2'b00:   n_sel = PHW'(N_LO);
            2'b01:   n_sel = PHW'(N_MID);
            default: n_sel = PHW'(N_HI);
        endcase
    end

    assign period_end = (ph == n_cur - PHW'(1));

    // Advance the tick and period counters; reload the period length at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= '0;
            seg   <= '0;
            n_cur <= n_sel;
        end else if (period_end) begin
            ph    <= '0;
            seg   <= seg + 2'd1;
            n_cur <= n_sel;
        end else begin
            ph    <= ph + PHW'(1);
        end
    end

endmodule

// File: rtl/skew_pair_cfg.sv
`timescale 1ns/1ps
// Per-section function select: latches the two selects at period end and decodes them.
// WIDE_STEP picks two-unit steps with divided corners; CORNER_INV turns the top corner into inversion.
module skew_pair_cfg #(
    parameter bit WIDE_STEP  = 1'b0,
    parameter bit CORNER_INV = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [1:0]                  f_hi,
    input  logic [1:0]                  f_lo,
    output skew_matrix_pkg::pair_fn_t   fn
);
    import skew_matrix_pkg::*;

    logic [3:0] idx_q;
    logic [3:0] rel;

    // Hold the select index; only reset or a period boundary may replace it.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            idx_q <= code_index(f_hi, f_lo);
        end
    end

    assign rel = idx_q - 4'd4;

    generate
        if (WIDE_STEP) begin : g_wide
            // Two-unit steps, corners give division or inversion.
            always_comb begin
                fn.kind   = FN_SHIFT;
                fn.offset = $signed(rel << 1);
                if (idx_q == 4'd0) begin
                    fn.kind   = FN_DIV2;
                    fn.offset = '0;
                end else if (idx_q == 4'd8) begin
                    fn.kind   = CORNER_INV ? FN_INV : FN_DIV4;
                    fn.offset = '0;
                end
            end
        end else begin : g_narrow
            // Single-unit steps across all nine codes.
            always_comb begin
                fn.kind   = FN_SHIFT;
                fn.offset = $signed(rel);
            end
        end
    endgenerate

endmodule

// File: rtl/skew_pair_out.sv
`timescale 1ns/1ps
// Output stage of one pair: forms the waveform from the phase state or the reference, then registers it.
// Assumes |offset| < n_cur and n_cur even, so one wrap step is enough.
module skew_pair_out #(
    parameter int PHW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  skew_matrix_pkg::pair_fn_t   fn,
    input  logic [PHW-1:0]              ph,
    input  logic [1:0]                  seg,
    input  logic [PHW-1:0]              n_cur,
    input  logic                        test_act,
    input  logic                        ref_lvl,
    input  logic [1:0]                  rdiv,
    output logic                        q0,
    output logic                        q1
);
    import skew_matrix_pkg::*;

    localparam int DW = PHW + 2;

    logic signed [DW-1:0] n_s;
    logic signed [DW-1:0] half_s;
    logic signed [DW-1:0] d_raw;
    logic signed [DW-1:0] d_wrap;
    logic                 shift_hi;
    logic                 gen_val;
    logic                 tst_val;
    logic                 nxt;

    // Shifted phase wrapped into one period, compared to the half period.
    always_comb begin
        n_s    = $signed({2'b00, n_cur});
        half_s = n_s >>> 1;
        d_raw  = $signed({2'b00, ph}) - DW'(fn.offset);
        if (d_raw < 0) begin
            d_wrap = d_raw + n_s;
        end else if (d_raw >= n_s) begin
            d_wrap = d_raw - n_s;
        end else begin
            d_wrap = d_raw;
        end
        shift_hi = (d_wrap < half_s);
    end

    // Pick the generated and the bypass value for this pair's function.
    always_comb begin
        case (fn.kind)
            FN_DIV2: begin gen_val = ~seg[0];   tst_val = rdiv[0];  end
            FN_DIV4: begin gen_val = ~seg[1];   tst_val = rdiv[1];  end
            FN_INV:  begin gen_val = ~shift_hi; tst_val = ~ref_lvl; end
            default: begin gen_val = shift_hi;  tst_val = ref_lvl;  end
        endcase
        nxt = test_act ? tst_val : gen_val;
    end

    // Register both drivers of the pair; reset holds them low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
        end else begin
            q0 <= nxt;
            q1 <= nxt;
        end
    end

endmodule

// File: rtl/skew_clk_matrix.sv
`timescale 1ns/1ps
// Four-section programmable skew clock matrix driven by a time-unit clock.
// Sections 1-2 shift by single units; 3-4 by two units with divided or inverted corners.
// Assumes all period lengths are even and larger than twice the largest offset.
module skew_clk_matrix #(
    parameter int N_LO  = 44,
    parameter int N_MID = 26,
    parameter int N_HI  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  range_sel,
    input  logic [1:0]  test_sel,
    input  logic        ref_lvl,
    input  logic [7:0]  sel_f1,
    input  logic [7:0]  sel_f0,
    output logic [3:0]  q0,
    output logic [3:0]  q1
);
    import skew_matrix_pkg::*;

    localparam int NPAIR = 4;
    localparam int NMAX  = (N_LO > N_MID) ? ((N_LO > N_HI) ? N_LO : N_HI)
                                          : ((N_MID > N_HI) ? N_MID : N_HI);
    localparam int PHW   = $clog2(NMAX + 1);

    logic [PHW-1:0]         ph;
    logic [1:0]             seg;
    logic [PHW-1:0]         n_cur;
    logic                   period_end;
    logic                   test_act;
    logic                   ref_d;
    logic [1:0]             rdiv;
    logic [1:0]             rdiv_nxt;
    pair_fn_t [NPAIR-1:0]   pair_fn;

    skew_phase_gen #(
        .N_LO (N_LO),
        .N_MID(N_MID),
        .N_HI (N_HI),
        .PHW  (PHW)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_sel (range_sel),
        .ph        (ph),
        .seg       (seg),
        .n_cur     (n_cur),
        .period_end(period_end)
    );

    assign test_act = (lvl_of(test_sel) != 2'b00);
    assign rdiv_nxt = rdiv + {1'b0, test_act & ref_lvl & ~ref_d};

    // Track reference rising edges for the bypass dividers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            rdiv  <= '0;
        end else begin
            ref_d <= ref_lvl;
            rdiv  <= rdiv_nxt;
        end
    end

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            skew_pair_cfg #(
                .WIDE_STEP (p >= 2),
                .CORNER_INV(p == 3)
            ) i_cfg (
                .clk  (clk),
                .rst_n(rst_n),
                .load (period_end),
                .f_hi (sel_f1[2*p +: 2]),
                .f_lo (sel_f0[2*p +: 2]),
                .fn   (pair_fn[p])
            );

            skew_pair_out #(
                .PHW(PHW)
            ) i_out (
                .clk     (clk),
                .rst_n   (rst_n),
                .fn      (pair_fn[p]),
                .ph      (ph),
                .seg     (seg),
                .n_cur   (n_cur),
                .test_act(test_act),
                .ref_lvl (ref_lvl),
                .rdiv    (rdiv_nxt),
                .q0      (q0[p]),
                .q1      (q1[p])
            );
        end
    endgenerate

endmodule

// File: rtl/skew_matrix_chk.sv
`timescale 1ns/1ps
// Property checker for the skew clock matrix, attached through bind.
// Assumes it sees the latched per-pair functions and the phase state of the top module.
module skew_matrix_chk #(
    parameter int PHW = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                test_act,
    input  logic                                ref_lvl,
    input  logic [3:0]                          q0,
    input  logic [3:0]                          q1,
    input  logic [PHW-1:0]                      ph,
    input  logic [PHW-1:0]                      n_cur,
    input  skew_matrix_pkg::pair_fn_t [3:0]     fn_all
);
    import skew_matrix_pkg::*;

    p_pair_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q0 == q1);

    p_reset_low_r9: assert property (@(posedge clk)
        !rst_n |=> (q0 == 4'd0 && q1 == 4'd0));

    p_phase_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ph < n_cur);

    p_cfg_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fn_all) || !$stable(n_cur)) |-> ph == '0);

    p_test_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_act && fn_all[0].kind == FN_SHIFT) |=> q0[0] == $past(ref_lvl));

endmodule

bind skew_clk_matrix skew_matrix_chk #(.PHW(PHW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .test_act(test_act),
    .ref_lvl (ref_lvl),
    .q0      (q0),
    .q1      (q1),
    .ph      (ph),
    .n_cur   (n_cur),
    .fn_all  (pair_fn)
);

// File: tb/test_skew_clk_matrix.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps ranges and codes, changes selects mid-period, and exercises the test bypass.
module test_skew_clk_matrix;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic [1:0] test_sel = 2'b00;
    logic       ref_lvl = 1'b0;
    logic [7:0] sel_f1 = 8'h55;
    logic [7:0] sel_f0 = 8'h55;
    logic [3:0] q0;
    logic [3:0] q1;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    int m_ph = 0, m_seg = 0, m_n = 44, m_rdiv = 0, m_refd = 0;
    int m_f1 [4];
    int m_f0 [4];

    skew_clk_matrix i_skew_clk_matrix (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .test_sel(test_sel),
        .ref_lvl(ref_lvl), .sel_f1(sel_f1), .sel_f0(sel_f0), .q0(q0), .q1(q1)
    );

    always #2.5 clk = ~clk;

    function automatic int lv(input int raw);
        return (raw == 3) ? 1 : raw;
    endfunction

    function automatic int n_of(input int raw);
        int l;
        l = lv(raw);
        return (l == 0) ? 44 : ((l == 1) ? 26 : 16);
    endfunction

    // Expected level of pair p from the requirements.
    function automatic bit exp_pair(input int p, input int f1, input int f0, input int ph,
                                    input int seg, input int n, input bit tst, input bit rf,
                                    input int rdn);
        int idx, k, d, kind;
        idx  = lv(f1) * 3 + lv(f0);
        kind = 0; k = 0;
        if (p < 2) k = idx - 4;
        else if (idx == 0) kind = 1;
        else if (idx == 8) kind = (p == 3) ? 3 : 2;
        else k = (idx - 4) * 2;
        if (tst) begin
            case (kind)
                1: return rdn[0];
                2: return rdn[1];
                3: return !rf;
                default: return rf;
            endcase
        end
        case (kind)
            1: return (seg % 2) == 0;
            2: return seg < 2;
            3: return !(ph < n / 2);
            default: begin
                d = ph - k;
                if (d < 0) d += n;
                if (d >= n) d -= n;
                return d < n / 2;
            end
        endcase
    endfunction

    task automatic latch_cfg();
        m_n = n_of(int'(range_sel));
        for (int p = 0; p < 4; p++) begin
            m_f1[p] = int'(sel_f1[2*p +: 2]);
            m_f0[p] = int'(sel_f0[2*p +: 2]);
        end
    endtask

    task automatic check(input bit act, input bit exp, input string tag, input int p, input string nm);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s pair %0d %s: actual %b expected %b at %0t", tag, p + 1, nm, act, exp, $time);
        end
    endtask

    // One time-unit edge: predict, advance the model, compare at the falling edge.
    task automatic tick(input string ov);
        bit [3:0] e;
        bit tst, rise;
        int rdn;
        string tg;
        @(posedge clk);
        tst  = (lv(int'(test_sel)) != 0);
        rise = tst && ref_lvl && (m_refd == 0);
        rdn  = (m_rdiv + (rise ? 1 : 0)) % 4;
        if (!rst_n) begin
            e = 4'd0;
            m_ph = 0; m_seg = 0; m_rdiv = 0; m_refd = 0;
            latch_cfg();
        end else begin
            for (int p = 0; p < 4; p++)
                e[p] = exp_pair(p, m_f1[p], m_f0[p], m_ph, m_seg, m_n, tst, ref_lvl, rdn);
            m_rdiv = rdn;
            m_refd = ref_lvl;
            if (m_ph == m_n - 1) begin
                m_ph = 0; m_seg = (m_seg + 1) % 4;
                latch_cfg();
            end else begin
                m_ph++;
            end
        end
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            if (ov != "") tg = ov;
            else tg = (p < 2) ? "R2" : ((p == 2) ? "R3" : "R4");
            check(q0[p], e[p], tg, p, "q0");
            check(q1[p], e[p], (ov == "R9") ? "R9" : "R5", p, "q1");
        end
    endtask

    task automatic set_all(input int idx);
        for (int p = 0; p < 4; p++) begin
            sel_f1[2*p +: 2] = 2'(idx / 3);
            sel_f0[2*p +: 2] = 2'(idx % 3);
        end
    endtask

    task automatic do_reset(input int cyc);
        rst_n = 1'b0;
        for (int i = 0; i < cyc; i++) tick("R9");
        rst_n = 1'b1;
    endtask

    initial begin
        // R9: reset state
        do_reset(4);
        // R1, R2, R3, R4: every range crossed with every function index
        for (int r = 0; r < 3; r++) begin
            for (int idx = 0; idx < 9; idx++) begin
                range_sel = 2'(r);
                set_all(idx);
                do_reset(2);
                for (int i = 0; i < 4 * n_of(r) + 3; i++) tick((idx == 4) ? "R1" : "");
            end
        end
        // R6: code 11 read as MID for range and function selects
        range_sel = 2'b11;
        sel_f1 = 8'hFF; sel_f0 = 8'hFF;
        do_reset(2);
        for (int i = 0; i < 2 * 26 + 5; i++) tick("R6");
        // R7: mixed codes, then a mid-period change of codes and range
        range_sel = 2'b10;
        sel_f1 = 8'b10_00_01_00; sel_f0 = 8'b00_10_10_01;
        do_reset(2);
        for (int i = 0; i < 16 + 7; i++) tick("R7");
        range_sel = 2'b00;
        sel_f1 = 8'b10_00_10_01; sel_f0 = 8'b10_00_00_10;
        for (int i = 0; i < 3 * 44 + 9; i++) tick("R7");
        // R8: bypass with both active test codes and an irregular reference
        for (int t = 1; t < 4; t++) begin
            for (int idx = 0; idx < 9; idx++) begin
                test_sel = 2'b00;
                ref_lvl = 1'b0;
                set_all(idx);
                range_sel = 2'(idx % 3);
                do_reset(2);
                test_sel = 2'(t);
                for (int i = 0; i < 40; i++) begin
                    ref_lvl = ((i * 7 + idx) % 5) < 2;
                    tick((t == 3) ? "R6" : "R8");
                end
            end
        end
        test_sel = 2'b00;
        // R9: reset asserted mid-run forces outputs low
        do_reset(3);
        for (int i = 0; i < 10; i++) tick("R9");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule